// File: doc/BRIEF.md
# Data Address Translation and Fault Checker

This block takes one data access and turns it into a physical address plus a fault verdict. It receives the virtual address, the access size, the access kind, a handful of request qualifiers, the processor mode state and the result of an external translation-buffer lookup. From these inputs it produces a physical address, an uncacheable marker, a 3-bit fault code and a 6-bit status word. The status word tells the fault handler why the access failed.

The checks run in a fixed priority order, and the first one that fails decides the fault:
1. alignment;
2. virtual-address shape (sign extension);
3. the kernel-only direct-mapped window;
4. lookup hit or miss;
5. per-mode permission;
6. fault-on-read or fault-on-write.

A path that passes all of these then goes through a physical-range check and a cacheability stage. All decisions are combinational. The result is registered, so it appears one clock after the request.

The translation storage is outside this block, and so is fault delivery. The caller presents the lookup result for the virtual page in the same cycle as the request.

Top module: `dtx_xlate`

## Requirements
- R1: While reset is held, and until the first request, `res_valid`, `res_pa`, `res_uncached`, `res_fault` and `res_status` are all zero.
- R2: A request sampled with `req_valid` high at a rising edge produces its result at that same edge, so the result is visible for the following cycle. Fault codes: 0 none, 1 misalignment, 2 access violation, 3 page fault, 4 table-walk miss, 5 normal miss, 6 machine check, 7 unimplemented space.
- R3: Misalignment means `va & (acc_size-1)` is nonzero, and it outranks every other check. It gives fault 1, and the status holds only bit 0 (write), set for writes. Status bits: 0 write, 1 access violation, 2 fault-on-read, 3 fault-on-write, 4 miss, 5 bad address.
- R4: With `phys_mode` set, the candidate physical address is the virtual address, and the lookup inputs have no effect.
- R5: Outside physical mode, an address whose bits 63:47 are not all equal gives fault 3, with status bits 5 and 1 set and bit 0 set for writes.
- R6: An address with bits 47:41 equal to 0x7E is in a direct-mapped window. The window is legal only when `cur_mode` is kernel (0); this test uses `cur_mode` even in privileged code. Otherwise the access gives fault 2 with status bit 1 and the write bit. On the legal path, the address is masked to 44 bits. If bit 40 is set, bits 43:40 are then forced to one; if bit 40 is clear, the address is masked to 40 bits.
- R7: A lookup miss gives fault 4 when `pte_walk` is set and fault 5 otherwise. Its status holds bit 4 and the write bit.
- R8: On a hit, the candidate address is `{tlb_ppn, va[12:0]}`. The effective mode is `alt_mode` when both `in_pal` and `use_alt` are set, kernel when only `in_pal` is set, and `cur_mode` otherwise. Modes are kernel 0, executive 1, supervisor 2 and user 3. The effective mode selects bit number mode of `tlb_rd_en` for reads or of `tlb_wr_en` for writes.
- R9: When the enable bit is clear, a write gives fault 3 with status bits 1 and 0, plus bit 3 if `tlb_fo_wr` is set. A read gives fault 2 with status bit 1, plus bit 2 if `tlb_fo_rd` is set.
- R10: When permission passes but the matching fault-on flag is set, the result is fault 3. The status is bit 2 alone for reads, or bits 3 and 0 for writes.
- R11: A candidate address with any bit at or above bit 44 set gives fault 6 with a zero status.
- R12: A candidate address with bit 43 set is reported with `res_uncached` high and bits 42:35 cleared. When bits 42:35 are all ones, it gives fault 7 instead.
- R13: Whenever `res_fault` is nonzero, `res_pa` and `res_uncached` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| acc_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| is_write | input | 1 | Access is a store |
| phys_mode | input | 1 | Bypass translation |
| use_alt | input | 1 | Use alternate mode in privileged code |
| pte_walk | input | 1 | Access is a page-table walk |
| cur_mode | input | 2 | Current processor mode |
| alt_mode | input | 2 | Alternate mode value |
| in_pal | input | 1 | Executing privileged code |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fo_rd | input | 1 | Entry faults on read |
| tlb_fo_wr | input | 1 | Entry faults on write |
| res_valid | output | 1 | Result present |
| res_pa | output | 64 | Physical address (zero on fault) |
| res_uncached | output | 1 | Access is uncacheable |
| res_fault | output | 3 | Fault code |
| res_status | output | 6 | Status bits for the handler |

## Verification
The hardest results to reach combine two later-stage conditions at once. One is a direct-mapped window address whose bit 40 forces the uncached bit, so that the window mapping and the cacheability clearing both show up in one result. The other is privileged code whose effective mode differs from `cur_mode`: the window test must still use `cur_mode`, while the permission test follows the alternate mode. The stimulus builds these from hand-picked addresses, with a window tag of 0x7E and bit 40 set. It pairs `in_pal`/`use_alt` settings with single-bit enable masks, so a mode mix-up changes the fault code that is seen.

// File: rtl/dtx_pkg.sv
// Shared encodings for the data translation checker: fault codes,
// status bit positions and processor mode values.
package dtx_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_PAGE     = 3'd3,
        FLT_MISS_PTE = 3'd4,
        FLT_MISS_NRM = 3'd5,
        FLT_MCHK     = 3'd6,
        FLT_UNIMP    = 3'd7
    } fault_e;

    localparam int FLT_W  = 3;
    localparam int ST_W   = 6;
    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FOR   = 2;
    localparam int ST_FOW   = 3;
    localparam int ST_MISS  = 4;
    localparam int ST_BADVA = 5;

    localparam int MODE_W = 2;
    localparam int NMODES = 1 << MODE_W;
    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

endpackage

// File: rtl/dtx_mode_sel.sv
// Effective-mode selection.
// Privileged code runs as kernel unless it asks for the alternate mode;
// ordinary code runs in the current mode. Assumes mode values are already legal.
module dtx_mode_sel
    import dtx_pkg::*;
(
    input  logic              in_pal,
    input  logic              use_alt,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    output logic [MODE_W-1:0] eff_mode
);

    // pick the mode that permission checks are made against
    always_comb begin
        if (in_pal) begin
            eff_mode = use_alt ? alt_mode : MODE_KERNEL;
        end else begin
            eff_mode = cur_mode;
        end
    end

endmodule

// File: rtl/dtx_perm_chk.sv
// Per-mode permission and fault-on evaluation for a lookup hit.
// Decodes the effective mode one-hot and tests it against the entry's
// read or write enable mask. Assumes enable bit n belongs to mode n.
module dtx_perm_chk
    import dtx_pkg::*;
(
    input  logic              is_write,
    input  logic [MODE_W-1:0] eff_mode,
    input  logic [NMODES-1:0] rd_en,
    input  logic [NMODES-1:0] wr_en,
    input  logic              fo_rd,
    input  logic              fo_wr,
    output logic              perm_ok,
    output logic              fo_set
);

    logic [NMODES-1:0] mode_oh;
    logic [NMODES-1:0] en_sel;

    // one decoder line per mode
    for (genvar m = 0; m < NMODES; m++) begin : g_dec
        assign mode_oh[m] = (eff_mode == MODE_W'(m));
    end

    // choose the mask for this access kind and test the mode's bit
    always_comb begin
        en_sel  = is_write ? wr_en : rd_en;
        perm_ok = |(mode_oh & en_sel);
        fo_set  = is_write ? fo_wr : fo_rd;
    end

endmodule

// File: rtl/dtx_pa_post.sv
// Physical-address post stage: range check and cacheability.
// Flags any bit above the implemented width. Recognises the uncached space,
// clears its middle field, and spots the unimplemented region inside it.
module dtx_pa_post #(
    parameter int PA_W      = 64,
    parameter int IMPL_W    = 44,
    parameter int CLR_LO    = 35
) (
    input  logic [PA_W-1:0] pa_in,
    output logic            mchk,
    output logic            unimp,
    output logic            uncached,
    output logic [PA_W-1:0] pa_out
);

    localparam int UC_BIT = IMPL_W - 1;
    localparam int CLR_HI = IMPL_W - 2;

    // classify the address and build the cleaned-up form
    always_comb begin
        mchk     = |pa_in[PA_W-1:IMPL_W];
        uncached = pa_in[UC_BIT];
        unimp    = uncached && (&pa_in[CLR_HI:CLR_LO]);
        pa_out   = pa_in;
        if (uncached) begin
            pa_out[CLR_HI:CLR_LO] = '0;
        end
    end

endmodule

// File: rtl/dtx_xlate.sv
// Data address translation and fault checker, top level.
// Walks the checks in fixed priority order and registers the verdict for
// one cycle. Assumes the lookup result matches the presented address in
// the same cycle, and that acc_size is a power of two.
module dtx_xlate
    import dtx_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VA_IMPL_W  = 48,
    parameter int PA_IMPL_W  = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32,
    parameter int SIZE_W     = 4,
    parameter int SP_LO      = 41,
    parameter int SP_TAG     = 'h7E,
    parameter int SP_SEXT    = 40,
    parameter int UC_CLR_LO  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   va,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              is_write,
    input  logic              phys_mode,
    input  logic              use_alt,
    input  logic              pte_walk,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic              in_pal,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fo_rd,
    input  logic              tlb_fo_wr,
    output logic              res_valid,
    output logic [VA_W-1:0]   res_pa,
    output logic              res_uncached,
    output logic [2:0]        res_fault,
    output logic [5:0]        res_status
);

    localparam int SP_W     = VA_IMPL_W - SP_LO;
    localparam int SEXT_HI  = VA_W - 1;
    localparam int SEXT_LO  = VA_IMPL_W - 1;
    localparam int HIT_W    = PPN_W + PAGE_SHIFT;
    localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_IMPL_W){1'b0}}, {PA_IMPL_W{1'b1}}};
    localparam logic [VA_W-1:0] LOW_MASK  = {{(VA_W-SP_SEXT){1'b0}}, {SP_SEXT{1'b1}}};
    localparam logic [VA_W-1:0] HIGH_FILL = IMPL_MASK & ~LOW_MASK;

    logic [MODE_W-1:0] eff_mode;
    logic              perm_ok;
    logic              fo_set;
    logic              misaligned;
    logic              va_ok;
    logic              in_sp;
    logic [VA_W-1:0]   sp_raw;
    logic [VA_W-1:0]   sp_pa;
    logic [VA_W-1:0]   hit_pa;
    logic [VA_W-1:0]   cand_pa;
    logic              post_mchk;
    logic              post_unimp;
    logic              post_uc;
    logic [VA_W-1:0]   post_pa;
    logic              run_post;
    fault_e            nxt_fault;
    logic [ST_W-1:0]   nxt_status;
    logic [VA_W-1:0]   nxt_pa;
    logic              nxt_uc;

    dtx_mode_sel u_mode (
        .in_pal   (in_pal),
        .use_alt  (use_alt),
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .eff_mode (eff_mode)
    );

    dtx_perm_chk u_perm (
        .is_write (is_write),
        .eff_mode (eff_mode),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fo_rd    (tlb_fo_rd),
        .fo_wr    (tlb_fo_wr),
        .perm_ok  (perm_ok),
        .fo_set   (fo_set)
    );

    // early address classification: alignment, shape, window membership
    always_comb begin
        misaligned = |(va[SIZE_W-1:0] & (acc_size - SIZE_W'(1)));
        va_ok      = (&va[SEXT_HI:SEXT_LO]) || !(|va[SEXT_HI:SEXT_LO]);
        in_sp      = (va[VA_IMPL_W-1:SP_LO] == SP_W'(SP_TAG));
    end

    // window mapping and hit mapping, then the candidate for the post stage
    always_comb begin
        sp_raw = va & IMPL_MASK;
        if (sp_raw[SP_SEXT]) begin
            sp_pa = sp_raw | HIGH_FILL;
        end else begin
            sp_pa = sp_raw & LOW_MASK;
        end
        hit_pa = VA_W'({tlb_ppn, va[PAGE_SHIFT-1:0]});
        if (phys_mode) begin
            cand_pa = va;
        end else if (in_sp) begin
            cand_pa = sp_pa;
        end else begin
            cand_pa = hit_pa;
        end
    end

    dtx_pa_post #(
        .PA_W   (VA_W),
        .IMPL_W (PA_IMPL_W),
        .CLR_LO (UC_CLR_LO)
    ) u_post (
        .pa_in    (cand_pa),
        .mchk     (post_mchk),
        .unimp    (post_unimp),
        .uncached (post_uc),
        .pa_out   (post_pa)
    );

    // priority chain: first failing check decides fault and status
    always_comb begin
        nxt_fault  = FLT_NONE;
        nxt_status = '0;
        nxt_pa     = '0;
        nxt_uc     = 1'b0;
        run_post   = 1'b0;
        if (misaligned) begin
            nxt_fault         = FLT_ALIGN;
            nxt_status[ST_WR] = is_write;
        end else if (phys_mode) begin
            run_post = 1'b1;
        end else if (!va_ok) begin
            nxt_fault            = FLT_PAGE;
            nxt_status[ST_WR]    = is_write;
            nxt_status[ST_ACV]   = 1'b1;
            nxt_status[ST_BADVA] = 1'b1;
        end else if (in_sp) begin
            if (cur_mode != MODE_KERNEL) begin
                nxt_fault          = FLT_ACV;
                nxt_status[ST_WR]  = is_write;
                nxt_status[ST_ACV] = 1'b1;
            end else begin
                run_post = 1'b1;
            end
        end else if (!tlb_hit) begin
            nxt_fault           = pte_walk ? FLT_MISS_PTE : FLT_MISS_NRM;
            nxt_status[ST_WR]   = is_write;
            nxt_status[ST_MISS] = 1'b1;
        end else if (!perm_ok) begin
            nxt_status[ST_ACV] = 1'b1;
            if (is_write) begin
                nxt_fault          = FLT_PAGE;
                nxt_status[ST_WR]  = 1'b1;
                nxt_status[ST_FOW] = tlb_fo_wr;
            end else begin
                nxt_fault          = FLT_ACV;
                nxt_status[ST_FOR] = tlb_fo_rd;
            end
        end else if (fo_set) begin
            nxt_fault          = FLT_PAGE;
            nxt_status[ST_WR]  = is_write;
            nxt_status[ST_FOW] = is_write;
            nxt_status[ST_FOR] = !is_write;
        end else begin
            run_post = 1'b1;
        end

        if (run_post) begin
            if (post_mchk) begin
                nxt_fault = FLT_MCHK;
            end else if (post_unimp) begin
                nxt_fault = FLT_UNIMP;
            end else begin
                nxt_pa = post_pa;
                nxt_uc = post_uc;
            end
        end
    end

    // result register: one cycle from request to verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_pa       <= '0;
            res_uncached <= 1'b0;
            res_fault    <= FLT_NONE;
            res_status   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_pa       <= nxt_pa;
                res_uncached <= nxt_uc;
                res_fault    <= nxt_fault;
                res_status   <= nxt_status;
            end
        end
    end

endmodule

// File: rtl/dtx_xlate_chk.sv
// Property checker for dtx_xlate, bound to every instance of it.
// Relates the registered verdict to the request of the previous cycle
// and the output fields to each other.
module dtx_xlate_chk
    import dtx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_IMPL_W = 44,
    parameter int SIZE_W    = 4,
    parameter int UC_CLR_LO = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   va,
    input logic [SIZE_W-1:0] acc_size,
    input logic              res_valid,
    input logic [VA_W-1:0]   res_pa,
    input logic              res_uncached,
    input logic [2:0]        res_fault,
    input logic [5:0]        res_status
);

    // misalignment outranks everything (R3)
    a_r3_align_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && (($past(va[SIZE_W-1:0]) & ($past(acc_size) - SIZE_W'(1))) != '0))
        |-> (res_fault == FLT_ALIGN && (res_status & ~6'b000001) == 6'd0));

    // misses always report the miss bit and never a violation (R7)
    a_r7_miss_status: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_fault == FLT_MISS_PTE || res_fault == FLT_MISS_NRM))
        |-> (res_status[ST_MISS] && !res_status[ST_ACV]));

    // a clean result never carries bits beyond the implemented width (R11)
    a_r11_pa_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == FLT_NONE) |-> (res_pa[VA_W-1:PA_IMPL_W] == '0));

    // uncached results are clean and have the middle field cleared (R12)
    a_r12_uc_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_uncached)
        |-> (res_fault == FLT_NONE && res_pa[PA_IMPL_W-1]
             && res_pa[PA_IMPL_W-2:UC_CLR_LO] == '0));

    // faults carry no address (R13)
    a_r13_pa_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != FLT_NONE) |-> (res_pa == '0 && !res_uncached));

    // machine check and unimplemented space report an empty status (R11)
    a_r11_mchk_status: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_fault == FLT_MCHK || res_fault == FLT_UNIMP)) |-> (res_status == '0));

endmodule

bind dtx_xlate dtx_xlate_chk #(
    .VA_W      (VA_W),
    .PA_IMPL_W (PA_IMPL_W),
    .SIZE_W    (SIZE_W),
    .UC_CLR_LO (UC_CLR_LO)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .va           (va),
    .acc_size     (acc_size),
    .res_valid    (res_valid),
    .res_pa       (res_pa),
    .res_uncached (res_uncached),
    .res_fault    (res_fault),
    .res_status   (res_status)
);

// File: tb/dtx_xlate_test.sv
// Scoreboard bench: the driver computes expectations from the requirements
// and queues them; the monitor compares each registered result in order.
module dtx_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] s_va = '0;
    logic [3:0]  s_size = 4'd1;
    logic        s_wr = 1'b0, s_phys = 1'b0, s_alt = 1'b0, s_pte = 1'b0, s_pal = 1'b0;
    logic [1:0]  s_cur = '0, s_altm = '0;
    logic        s_hit = 1'b0;
    logic [31:0] s_ppn = '0;
    logic [3:0]  s_ren = '0, s_wen = '0;
    logic        s_for = 1'b0, s_fow = 1'b0;

    logic        res_valid;
    logic [63:0] res_pa;
    logic        res_uncached;
    logic [2:0]  res_fault;
    logic [5:0]  res_status;

    int total = 0;
    int bad = 0;

    logic [63:0] q_pa[$];
    logic        q_uc[$];
    logic [2:0]  q_f[$];
    logic [5:0]  q_st[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    dtx_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(s_va),
        .acc_size(s_size), .is_write(s_wr), .phys_mode(s_phys), .use_alt(s_alt),
        .pte_walk(s_pte), .cur_mode(s_cur), .alt_mode(s_altm), .in_pal(s_pal),
        .tlb_hit(s_hit), .tlb_ppn(s_ppn), .tlb_rd_en(s_ren), .tlb_wr_en(s_wen),
        .tlb_fo_rd(s_for), .tlb_fo_wr(s_fow), .res_valid(res_valid), .res_pa(res_pa),
        .res_uncached(res_uncached), .res_fault(res_fault), .res_status(res_status)
    );

    // expected verdict, written from the requirement text
    function automatic void model(output logic [63:0] pa, output logic uc,
                                  output logic [2:0] f, output logic [5:0] st);
        logic [63:0] c;
        logic        post;
        logic [1:0]  em;
        logic        ok;
        logic        fo;
        pa = '0; uc = 1'b0; f = 3'd0; st = '0; post = 1'b0; c = '0;
        em = s_pal ? (s_alt ? s_altm : 2'd0) : s_cur;
        if ((s_va[3:0] & (s_size - 4'd1)) != 4'd0) begin
            f = 3'd1; st[0] = s_wr;
        end else if (s_phys) begin
            c = s_va; post = 1'b1;
        end else if (!((&s_va[63:47]) || (s_va[63:47] == '0))) begin
            f = 3'd3; st = 6'b100010; st[0] = s_wr;
        end else if (s_va[47:41] == 7'h7E) begin
            if (s_cur != 2'd0) begin
                f = 3'd2; st = 6'b000010; st[0] = s_wr;
            end else begin
                c = s_va & 64'h0000_0FFF_FFFF_FFFF;
                if (c[40]) c = c | 64'h0000_0F00_0000_0000;
                else       c = c & 64'h0000_00FF_FFFF_FFFF;
                post = 1'b1;
            end
        end else if (!s_hit) begin
            f = s_pte ? 3'd4 : 3'd5; st = 6'b010000; st[0] = s_wr;
        end else begin
            ok = s_wr ? s_wen[em] : s_ren[em];
            fo = s_wr ? s_fow : s_for;
            if (!ok) begin
                f = s_wr ? 3'd3 : 3'd2;
                st[1] = 1'b1; st[0] = s_wr; st[3] = s_wr & s_fow; st[2] = !s_wr & s_for;
            end else if (fo) begin
                f = 3'd3; st[0] = s_wr; st[3] = s_wr; st[2] = !s_wr;
            end else begin
                c = {19'b0, s_ppn, s_va[12:0]}; post = 1'b1;
            end
        end
        if (post) begin
            if (c[63:44] != '0) f = 3'd6;
            else if (c[43] && (&c[42:35])) f = 3'd7;
            else begin
                pa = c;
                if (c[43]) begin uc = 1'b1; pa[42:35] = '0; end
            end
        end
    endfunction

    // put every stimulus field back to a benign aligned kernel read
    task automatic clear_stim();
        s_va = '0; s_size = 4'd1; s_wr = 1'b0; s_phys = 1'b0; s_alt = 1'b0;
        s_pte = 1'b0; s_pal = 1'b0; s_cur = 2'd0; s_altm = 2'd0; s_hit = 1'b0;
        s_ppn = '0; s_ren = 4'hF; s_wen = 4'hF; s_for = 1'b0; s_fow = 1'b0;
    endtask

    // driver: queue expectation and present the request for one edge
    task automatic send(input string tag);
        logic [63:0] pa; logic uc; logic [2:0] f; logic [5:0] st;
        model(pa, uc, f, st);
        q_pa.push_back(pa); q_uc.push_back(uc); q_f.push_back(f);
        q_st.push_back(st); q_tag.push_back(tag);
        req_valid = 1'b1;
    endtask

    // monitor: compare each result against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            total++;
            if (q_f.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected result: actual fault=%0d expected none queued", res_fault);
            end else begin
                logic [63:0] e_pa; logic e_uc; logic [2:0] e_f; logic [5:0] e_st; string t;
                e_pa = q_pa.pop_front(); e_uc = q_uc.pop_front(); e_f = q_f.pop_front();
                e_st = q_st.pop_front(); t = q_tag.pop_front();
                if (res_pa !== e_pa || res_uncached !== e_uc || res_fault !== e_f || res_status !== e_st) begin
                    bad++;
                    $display("FAIL %s: actual pa=%h uc=%0d f=%0d st=%b expected pa=%h uc=%0d f=%0d st=%b",
                             t, res_pa, res_uncached, res_fault, res_status, e_pa, e_uc, e_f, e_st);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_stim();
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (res_valid !== 1'b0 || res_pa !== '0 || res_uncached !== 1'b0 || res_fault !== 3'd0 || res_status !== '0) begin
            bad++;
            $display("FAIL R1: actual v=%0d pa=%h f=%0d st=%b expected all zero", res_valid, res_pa, res_fault, res_status);
        end
        rst_n = 1'b1;

        // R3: misalignment, including over an otherwise invalid address
        @(negedge clk); clear_stim(); s_va = 64'h1002; s_size = 4'd4; s_wr = 1'b1; send("R3 align write");
        @(negedge clk); clear_stim(); s_va = 64'h0000_8000_0000_0001; s_size = 4'd2; send("R3 align over bad va");
        @(negedge clk); clear_stim(); s_va = 64'h0000_0000_0000_1008; s_size = 4'd8; s_phys = 1'b1; send("R3 aligned dword");
        // R4: physical mode ignores lookup inputs
        @(negedge clk); clear_stim(); s_phys = 1'b1; s_va = 64'h0000_0123_4568; s_hit = 1'b0; send("R4 phys no lookup");
        @(negedge clk); clear_stim(); s_phys = 1'b1; s_va = 64'h0000_0123_4568; s_hit = 1'b1; s_ppn = 32'h55; s_ren = 4'h0; send("R4 phys ignores hit");
        // R12: uncached space and unimplemented region
        @(negedge clk); clear_stim(); s_phys = 1'b1; s_va = 64'h0000_0FF0_0000_0010; send("R12 uncached clear");
        @(negedge clk); clear_stim(); s_phys = 1'b1; s_va = 64'h0000_0FF8_0000_0000; send("R12 unimplemented");
        // R11: out-of-range physical addresses
        @(negedge clk); clear_stim(); s_phys = 1'b1; s_va = 64'h0001_0000_0000_0000; send("R11 phys mchk");
        // R5: bad virtual address
        @(negedge clk); clear_stim(); s_va = 64'h0000_8000_0000_0000; s_wr = 1'b1; send("R5 bad va write");
        @(negedge clk); clear_stim(); s_va = 64'hFFFF_0000_0000_0000; send("R5 bad va read");
        // R6: direct-mapped window
        @(negedge clk); clear_stim(); s_va = 64'hFFFF_FC00_1234_5678; send("R6 window low");
        @(negedge clk); clear_stim(); s_va = 64'hFFFF_FD00_0000_0040; send("R6 window bit40 uncached");
        @(negedge clk); clear_stim(); s_va = 64'hFFFF_FC00_0000_0000; s_cur = 2'd3; s_wr = 1'b1; send("R6 window user");
        @(negedge clk); clear_stim(); s_va = 64'hFFFF_FC00_0000_0000; s_cur = 2'd1; s_pal = 1'b1; send("R6 window uses cur_mode");
        // R7: misses
        @(negedge clk); clear_stim(); s_va = 64'h2000; s_pte = 1'b1; s_wr = 1'b1; send("R7 walk miss");
        @(negedge clk); clear_stim(); s_va = 64'h2000; send("R7 normal miss");
        // R8: hit mapping and effective mode
        @(negedge clk); clear_stim(); s_va = 64'h0045_6ABC; s_hit = 1'b1; s_ppn = 32'h1234; s_ren = 4'b0001; send("R8 kernel read hit");
        @(negedge clk); clear_stim(); s_va = 64'h0045_6ABC; s_hit = 1'b1; s_ppn = 32'h1234; s_ren = 4'b0001;
            s_pal = 1'b1; s_alt = 1'b1; s_altm = 2'd3; send("R8 pal alt user denied");
        @(negedge clk); clear_stim(); s_va = 64'h0045_6ABC; s_hit = 1'b1; s_ppn = 32'h1234; s_ren = 4'b0001;
            s_pal = 1'b1; s_cur = 2'd3; send("R8 pal kernel allowed");
        @(negedge clk); clear_stim(); s_va = 64'h0045_6ABC; s_hit = 1'b1; s_ppn = 32'h1234; s_wen = 4'b0100;
            s_cur = 2'd2; s_wr = 1'b1; send("R8 supervisor write");
        // R9: permission failures
        @(negedge clk); clear_stim(); s_va = 64'h4000; s_hit = 1'b1; s_ren = 4'b0001; s_cur = 2'd3; s_for = 1'b1; send("R9 read denied fo");
        @(negedge clk); clear_stim(); s_va = 64'h4000; s_hit = 1'b1; s_ren = 4'b0001; s_cur = 2'd3; send("R9 read denied");
        @(negedge clk); clear_stim(); s_va = 64'h4000; s_hit = 1'b1; s_wen = 4'b0001; s_cur = 2'd3; s_wr = 1'b1; s_fow = 1'b1; send("R9 write denied fo");
        // R10: fault-on only
        @(negedge clk); clear_stim(); s_va = 64'h4000; s_hit = 1'b1; s_for = 1'b1; send("R10 fault on read");
        @(negedge clk); clear_stim(); s_va = 64'h4000; s_hit = 1'b1; s_fow = 1'b1; s_wr = 1'b1; send("R10 fault on write");
        // R11 and R12 on the hit path
        @(negedge clk); clear_stim(); s_va = 64'h4010; s_hit = 1'b1; s_ppn = 32'hFFFF_FFFF; send("R11 hit mchk");
        @(negedge clk); clear_stim(); s_va = 64'h4010; s_hit = 1'b1; s_ppn = 32'h4000_0001; send("R12 hit uncached");
        // R13: fault keeps previous address out of the result
        @(negedge clk); clear_stim(); s_va = 64'h8000; s_hit = 1'b0; send("R13 fault after hit");

        @(negedge clk); req_valid = 1'b0; clear_stim();
        repeat (3) @(negedge clk);
        // R2: one result per request, nothing left over
        total++;
        if (q_f.size() != 0) begin
            bad++;
            $display("FAIL R2: actual %0d results missing expected 0", q_f.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule